// File: doc/BRIEF.md
# Watchdog Timeout Divider Planner

This block turns a requested watchdog timeout, given as a count of watchdog clock ticks, into the two settings a power-of-two watchdog needs. The first is a 3-bit prescaler code that selects a divide-by-2^scale, with scale between 2 and 8. The second is a 12-bit reload value. The block picks the smallest divider that lets the timeout fit the 12-bit reload range. It clamps both the divider exponent and the reload count to their legal ranges, and it flags requests too large for its 16-bit search.

A request is made by pulsing `start` with the tick count on `tick_in`. The block raises `busy` while it works. It then pulses `done` for one cycle, and in that same cycle the prescaler, reload and saturation outputs become valid. Those outputs hold their values until the next `done`. Conversion from time units to ticks happens upstream, and loading the results into the watchdog happens downstream.

Top module: `tmo_div_planner`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `presc_code`, `reload_val` and `saturated` are all 0.
- R2: The block forms the chunk count ceil(tick_in / 4096) without losing any bits. It takes the low 16 bits of that count as v and finds the exponent e, the smallest value with 2^e >= v. When v is 0, e is 0.
- R3: `saturated` is 1 exactly when the chunk count is 65536 or more, which is when tick_in >= 268431361. When `saturated` is 1, `reload_val` is 4095.
- R4: `presc_code` equals scale - 2, where scale is e limited to the range 2..8, so the code never exceeds 6.
- R5: `reload_val` equals r - 1, where r is tick_in shifted right by scale and then limited to the range 1..4096.
- R6: `done` is a single-cycle pulse. It rises at rising edge number e + 4 when the edge that samples `start` counts as edge 1, so it rises no later than edge 20.
- R7: A `start` seen while `busy` is 1 is ignored. It yields no extra `done` and does not change the result of the request already in progress.
- R8: `busy` is 1 from the cycle after an accepted `start` until the cycle in which `done` is 1, and it is 0 in that cycle.
- R9: `presc_code`, `reload_val` and `saturated` change only in a cycle where `done` is 1, and they hold between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted only while idle |
| tick_in | input | 32 | Desired timeout in watchdog ticks |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse; results valid |
| presc_code | output | 3 | Divider code, scale - 2 |
| reload_val | output | 12 | Reload count, r - 1 |
| saturated | output | 1 | Chunk count did not fit in 16 bits |

## Verification
The delay to `done` is not fixed: it is e + 4 edges, where e is the exponent the search finds. For every request, the bench computes e from the tick count and records the cycle counter value at which `done` must appear. The monitor samples on falling edges. Each time it sees `done`, it compares that cycle, and the three result fields sampled in the same cycle, with the item at the head of the scoreboard. One cycle after each accepted start, the bench samples `busy`. After each result, it watches the idle gap so that a stray second pulse or a drifting output is caught.

// File: rtl/tmo_div_pkg.sv
package tmo_div_pkg;

    localparam int TICK_W   = 32;
    localparam int RELOAD_W = 12;
    localparam int PRESC_W  = 3;
    localparam int SEARCH_W = 16;
    localparam int EXP_LO   = 2;
    localparam int EXP_HI   = 8;

    localparam int CHUNK_SH = RELOAD_W;
    localparam int CHUNK_W  = TICK_W - CHUNK_SH + 1;
    localparam int EXP_W    = $clog2(SEARCH_W + 1);
    localparam int RES_MAX  = 1 << RELOAD_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHUNK,
        ST_SEARCH,
        ST_FINISH
    } plan_state_e;

    typedef struct packed {
        logic [PRESC_W-1:0]  presc;
        logic [RELOAD_W-1:0] reload;
        logic                sat;
    } plan_result_t;

    function automatic logic [EXP_W-1:0] limit_exp(input logic [EXP_W-1:0] e);
        if (e < EXP_W'(EXP_LO))
            return EXP_W'(EXP_LO);
        else if (e > EXP_W'(EXP_HI))
            return EXP_W'(EXP_HI);
        else
            return e;
    endfunction

endpackage

// File: rtl/tmo_div_chunker.sv
module tmo_div_chunker
    import tmo_div_pkg::*;
#(
    parameter int T_W = TICK_W,
    parameter int SH  = CHUNK_SH,
    parameter int V_W = SEARCH_W
) (
    input  logic [T_W-1:0] tick,
    output logic [V_W-1:0] v,
    output logic           sat
);
    localparam int C_W = T_W - SH + 1;

    logic [C_W-1:0] chunks;

    // ceil(tick / 2^SH): upper part plus one when any low bit is set
    always_comb begin
        chunks = {1'b0, tick[T_W-1:SH]} + C_W'(|tick[SH-1:0]);
        v      = chunks[V_W-1:0];
        sat    = |chunks[C_W-1:V_W];
    end

endmodule

// File: rtl/tmo_div_exp_search.sv
module tmo_div_exp_search
    import tmo_div_pkg::*;
#(
    parameter int V_W = SEARCH_W,
    parameter int E_W = EXP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [V_W-1:0] v_in,
    output logic           found,
    output logic [E_W-1:0] e_out
);
    logic           active;
    logic [V_W-1:0] v_q;
    logic [E_W-1:0] e_q;
    logic [V_W:0]   pow;
    logic           hit;

    always_comb begin
        pow   = (V_W+1)'(1) << e_q;
        hit   = pow >= {1'b0, v_q};
        found = active && hit;
        e_out = e_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            v_q    <= '0;
            e_q    <= '0;
        end else if (load) begin
            active <= 1'b1;
            v_q    <= v_in;
            e_q    <= '0;
        end else if (active) begin
            if (hit)
                active <= 1'b0;
            else
                e_q <= e_q + 1'b1;
        end
    end

    // R2: the search never runs past the widest exponent
    p_exp_bound_r2: assert property (@(posedge clk) disable iff (rst)
        active |-> (e_q <= E_W'(V_W)));

    // R2: a nonzero result is minimal, since the previous power is still short
    p_exp_minimal_r2: assert property (@(posedge clk) disable iff (rst)
        (found && e_q != '0) |-> ((pow >> 1) < {1'b0, v_q}));

endmodule

// File: rtl/tmo_div_encode.sv
module tmo_div_encode
    import tmo_div_pkg::*;
#(
    parameter int T_W = TICK_W,
    parameter int E_W = EXP_W,
    parameter int R_W = RELOAD_W,
    parameter int P_W = PRESC_W
) (
    input  logic [T_W-1:0] tick,
    input  logic [E_W-1:0] e,
    output logic [P_W-1:0] presc,
    output logic [R_W-1:0] reload
);
    localparam int RMAX = 1 << R_W;

    logic [E_W-1:0] scale;
    logic [T_W-1:0] resid;
    logic [T_W-1:0] resid_lim;

    always_comb begin
        scale = limit_exp(e);
        resid = tick >> scale;
        if (resid == '0)
            resid_lim = T_W'(1);
        else if (resid > T_W'(RMAX))
            resid_lim = T_W'(RMAX);
        else
            resid_lim = resid;
        presc  = P_W'(scale - E_W'(EXP_LO));
        reload = R_W'(resid_lim - T_W'(1));
    end

endmodule

// File: rtl/tmo_div_planner.sv
module tmo_div_planner
    import tmo_div_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [TICK_W-1:0]   tick_in,
    output logic                busy,
    output logic                done,
    output logic [PRESC_W-1:0]  presc_code,
    output logic [RELOAD_W-1:0] reload_val,
    output logic                saturated
);
    localparam int LAT_MAX = SEARCH_W + 4;
    localparam int LAT_W   = $clog2(LAT_MAX + 1);

    plan_state_e         state;
    logic [TICK_W-1:0]   tick_q;
    logic                sat_q;
    logic [EXP_W-1:0]    e_q;
    plan_result_t        res_q;
    logic                done_q;

    logic [SEARCH_W-1:0] chunk_v;
    logic                chunk_sat;
    logic                srch_found;
    logic [EXP_W-1:0]    srch_e;
    logic [PRESC_W-1:0]  enc_presc;
    logic [RELOAD_W-1:0] enc_reload;
    logic                srch_load;

    assign srch_load = (state == ST_CHUNK);

    tmo_div_chunker #(
        .T_W (TICK_W),
        .SH  (CHUNK_SH),
        .V_W (SEARCH_W)
    ) u_chunk (
        .tick (tick_q),
        .v    (chunk_v),
        .sat  (chunk_sat)
    );

    tmo_div_exp_search #(
        .V_W (SEARCH_W),
        .E_W (EXP_W)
    ) u_search (
        .clk   (clk),
        .rst   (rst),
        .load  (srch_load),
        .v_in  (chunk_v),
        .found (srch_found),
        .e_out (srch_e)
    );

    tmo_div_encode #(
        .T_W (TICK_W),
        .E_W (EXP_W),
        .R_W (RELOAD_W),
        .P_W (PRESC_W)
    ) u_enc (
        .tick   (tick_q),
        .e      (e_q),
        .presc  (enc_presc),
        .reload (enc_reload)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tick_q <= '0;
            sat_q  <= 1'b0;
            e_q    <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        tick_q <= tick_in;
                        state  <= ST_CHUNK;
                    end
                end
                ST_CHUNK: begin
                    sat_q <= chunk_sat;
                    state <= ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (srch_found) begin
                        e_q   <= srch_e;
                        state <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    res_q.presc  <= enc_presc;
                    res_q.reload <= enc_reload;
                    res_q.sat    <= sat_q;
                    done_q       <= 1'b1;
                    state        <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign presc_code = res_q.presc;
    assign reload_val = res_q.reload;
    assign saturated  = res_q.sat;

    // cycle counter for the latency window check
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy)
            lat_cnt <= '0;
        else
            lat_cnt <= lat_cnt + 1'b1;
    end

    // R6: done never lasts two cycles
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6: a request never stays busy beyond its worst-case window
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lat_cnt < LAT_W'(LAT_MAX - 1)));

    // R8: an accepted start makes the block busy on the next cycle
    p_busy_after_start_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R8: done appears only right after a busy cycle, and busy is low with it
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy) && !busy));

    // R7: the captured request cannot be overwritten while busy
    p_capture_held_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(tick_q));

    // R9: the result fields move only together with done
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(res_q));

    // R4: the divider code stays inside the clamped exponent range
    p_presc_range_r4: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (presc_code <= PRESC_W'(EXP_HI - EXP_LO)));

    // R3: an oversized request always yields the largest reload
    p_sat_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (done_q && saturated) |-> (&reload_val));

endmodule

// File: tb/sim_tmo_div_planner.sv
module sim_tmo_div_planner;
    import tmo_div_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] tick_in = '0;
    logic        busy, done, saturated;
    logic [2:0]  presc_code;
    logic [11:0] reload_val;

    always #10 clk = ~clk;  // 50 MHz

    tmo_div_planner u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tick_in    (tick_in),
        .busy       (busy),
        .done       (done),
        .presc_code (presc_code),
        .reload_val (reload_val),
        .saturated  (saturated)
    );

    typedef struct {
        logic [2:0]  presc;
        logic [11:0] reload;
        logic        sat;
        int          e;
        longint      cyc;
    } exp_item_t;

    exp_item_t sb[$];
    exp_item_t last_exp;
    int        n_checks = 0;
    int        n_fail   = 0;
    longint    cyc      = 0;
    logic      prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic exp_item_t model(input logic [31:0] t);
        exp_item_t   m;
        logic [32:0] s;
        logic [20:0] ch;
        logic [15:0] v;
        int          e;
        int          sc;
        logic [31:0] r;
        s  = {1'b0, t} + 33'd4095;
        ch = s[32:12];
        v  = ch[15:0];
        e  = 0;
        while ((33'd1 << e) < {17'd0, v}) e++;
        sc = (e < 2) ? 2 : ((e > 8) ? 8 : e);
        r  = t >> sc;
        if (r == 0) r = 1;
        if (r > 4096) r = 4096;
        m.presc  = 3'(sc - 2);
        m.reload = 12'(r - 1);
        m.sat    = (ch[20:16] != 0);
        m.e      = e;
        m.cyc    = 0;
        return m;
    endfunction

    // driver: push the expected item, pulse start, wait for the result
    task automatic send(input logic [31:0] t);
        exp_item_t m;
        m = model(t);
        @(negedge clk);
        m.cyc = cyc + 4 + m.e;
        sb.push_back(m);
        last_exp = m;
        tick_in = t;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", busy, 1);
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // monitor: compare every done pulse against the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) check("R6 done width", 2, 1);
            if (done) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected done", 1, 0);
                end else begin
                    exp_item_t m;
                    m = sb.pop_front();
                    check("R4 presc_code", presc_code, m.presc);
                    check("R5 reload_val", reload_val, m.reload);
                    check("R3 saturated", saturated, m.sat);
                    check("R2 R6 done cycle", cyc, m.cyc);
                    check("R8 busy low with done", busy, 0);
                end
            end
            prev_done <= done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
        check("R1 presc after reset", presc_code, 0);
        check("R1 reload after reset", reload_val, 0);
        check("R1 sat after reset", saturated, 0);

        send(32'd0);           // R5: residual clamps up to 1
        send(32'd1);
        send(32'd16384);       // exponent 2, full reload
        send(32'd16385);       // R2 rounding up to exponent 3
        send(32'd100000);
        send(32'd1048576);     // exponent 8
        send(32'd1048577);     // R4 exponent 9 clamps to 8
        send(32'd16777216);    // R5 residual clamps to 4096
        send(32'd268431360);   // widest search, latency 20
        send(32'd268431361);   // R3 first saturating value
        send(32'hFFFF_FFFF);   // R3 largest input

        // R7: a second start while busy must be ignored
        begin
            exp_item_t m;
            m = model(32'd300000);
            @(negedge clk);
            m.cyc = cyc + 4 + m.e;
            sb.push_back(m);
            last_exp = m;
            tick_in = 32'd300000;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            tick_in = 32'd5;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (sb.size() == 0);
            repeat (25) @(negedge clk);
            check("R7 R9 presc held", presc_code, last_exp.presc);
            check("R7 R9 reload held", reload_val, last_exp.reload);
        end

        repeat (10) @(negedge clk);
        check("R9 sat held", saturated, last_exp.sat);
        check("R9 no stray busy", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule